// File: doc/BRIEF.md
# Binary-Crossbar Spiking Core with Spike Router

This block is one time-stepped core of a spiking network. It has N input axons, N integrate-and-fire neurons and an N-by-N crossbar of one-bit synapses. Spike events arrive as axon numbers and are collected in an activity register. When a `tick` pulse starts a time step, the core takes a snapshot of that register and clears it. It walks the snapshot axon by axon. For every active axon it adds one to each neuron whose synapse bit for that axon is set.

After the scan, every neuron whose potential has reached the programmable threshold fires and is reset to zero. Each firing neuron looks up its own routing entry, which holds a destination core number and a destination axon. If the destination is this core, the spike is fed back into the local activity register. Any other destination leaves through a valid/ready output port, one packet per cycle. Feedback spikes and new input spikes both act in the following time step. The core returns to idle only after every packet from the current step has gone out.

The crossbar rows and the routing entries are written through simple write ports. The crossbar is held in a memory with a registered read, so a block RAM can hold it.

Top module: `spike_core`

## Requirements
- R1: Reset clears every neuron potential, the activity register and the output port. After reset `busy` and `pkt_valid` are low, and a step with no input fires no neuron, even at a threshold of 1.
- R2: During a step, each active axon adds one to every neuron whose crossbar bit is set. Bit j of the row written at axon address a connects axon a to neuron j. A neuron fires when its potential is greater than or equal to `thresh`.
- R3: A neuron below threshold does not fire and keeps its potential into later steps.
- R4: A neuron that fires is reset to zero.
- R5: Potentials are 8-bit and saturate at 255 instead of wrapping.
- R6: A firing neuron whose route core equals `LOCAL_ID` sends no packet on the output. Its route axon is set in the local activity register instead. Every other firing neuron sends a packet carrying its route core and route axon.
- R7: A spike fed back locally in step t acts in step t+1, not in step t.
- R8: Packets leave one per cycle, in ascending neuron order. While `pkt_valid` is high and `pkt_ready` is low, the packet is held unchanged.
- R9: `tick` is ignored while `busy` is high. Input events that arrive while `busy` is high are kept for the next step.
- R10: The activity register holds one bit per axon. Repeated events on one axon within a step count once, and the register is empty after the step that consumed it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thresh | input | PW | Firing threshold |
| xbar_we | input | 1 | Crossbar row write enable |
| xbar_axon | input | AW | Axon whose row is written |
| xbar_row | input | N | Synapse bits, bit j = neuron j |
| route_we | input | 1 | Routing entry write enable |
| route_nrn | input | AW | Neuron whose entry is written |
| route_core | input | CW | Destination core for that neuron |
| route_axon | input | AW | Destination axon for that neuron |
| ev_valid | input | 1 | Input spike event strobe |
| ev_axon | input | AW | Axon hit by the input event |
| tick | input | 1 | Start of time step (while idle) |
| busy | output | 1 | Step in progress |
| pkt_valid | output | 1 | Outgoing packet valid |
| pkt_ready | input | 1 | Downstream accepts packet |
| pkt_core | output | CW | Packet destination core |
| pkt_axon | output | AW | Packet destination axon |

## Verification
A table of eight steps runs a crossbar in which axon i reaches neurons i and i+1. Across the table, single axons, adjacent pairs, the wrap-around axon, all axons at once and empty steps each produce distinct firing sets. These sets separate a wrong row decode from a missing carry of sub-threshold potential and from a missing reset after a spike.

Directed steps cover the remaining cases:
- Repeated events on one axon show whether the activity register counts events or only marks the axon.
- A local route shows whether a fed-back spike is held back by one step.
- Holding `pkt_ready` low while a new `tick` and a new event arrive shows the packet hold, the tick rejection and the event retention.
- Thirty-two full-load steps at threshold 255 separate saturation from wrap-around.

// File: rtl/spike_core_pkg.sv
package spike_core_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_FIRE = 2'd2,
    ST_EMIT = 2'd3
  } core_state_t;
endpackage

// File: rtl/xbar_mem.sv
module xbar_mem #(
  parameter int N  = 8,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [N-1:0]  wrow,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [N-1:0]  rrow,
  output logic          rvalid
);
  logic [N-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wrow;
    rrow <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) rvalid <= 1'b0;
    else     rvalid <= re;
  end
endmodule

// File: rtl/route_table.sv
module route_table #(
  parameter int N  = 8,
  parameter int CW = 4,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [CW-1:0] wcore,
  input  logic [AW-1:0] waxon,
  input  logic [AW-1:0] raddr,
  output logic [CW-1:0] rcore,
  output logic [AW-1:0] raxon
);
  logic [CW-1:0] core_mem [N];
  logic [AW-1:0] axon_mem [N];

  always_ff @(posedge clk) begin
    if (we) begin
      core_mem[waddr] <= wcore;
      axon_mem[waddr] <= waxon;
    end
  end

  assign rcore = core_mem[raddr];
  assign raxon = axon_mem[raddr];
endmodule

// File: rtl/neuron_array.sv
module neuron_array #(
  parameter int N  = 8,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          add_en,
  input  logic [N-1:0]  add_vec,
  input  logic          fire_en,
  input  logic [PW-1:0] thr,
  output logic [N-1:0]  fire_hit
);
  localparam logic [PW-1:0] PMAX = {PW{1'b1}};

  for (genvar g = 0; g < N; g++) begin : g_nrn
    logic [PW-1:0] pot;

    assign fire_hit[g] = (pot >= thr);

    always_ff @(posedge clk) begin
      if (rst)                          pot <= '0;
      else if (fire_en && fire_hit[g])  pot <= '0;
      else if (add_en && add_vec[g])    pot <= (pot == PMAX) ? PMAX : pot + 1'b1;
    end

    // R4: a neuron that fires is cleared
    assert_fire_reset_R4: assert property (@(posedge clk) disable iff (rst)
      fire_en && fire_hit[g] |=> pot == '0);

    // R5: an increment never lowers the potential and never wraps to zero
    assert_no_wrap_R5: assert property (@(posedge clk) disable iff (rst)
      add_en && add_vec[g] && !fire_en |=> (pot >= $past(pot)) && (pot != '0));
  end
endmodule

// File: rtl/spike_core.sv
module spike_core
  import spike_core_pkg::*;
#(
  parameter int N        = 8,
  parameter int PW       = 8,
  parameter int CW       = 4,
  parameter int LOCAL_ID = 3,
  localparam int AW   = $clog2(N),
  localparam int CNTW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] thresh,
  input  logic          xbar_we,
  input  logic [AW-1:0] xbar_axon,
  input  logic [N-1:0]  xbar_row,
  input  logic          route_we,
  input  logic [AW-1:0] route_nrn,
  input  logic [CW-1:0] route_core,
  input  logic [AW-1:0] route_axon,
  input  logic          ev_valid,
  input  logic [AW-1:0] ev_axon,
  input  logic          tick,
  output logic          busy,
  output logic          pkt_valid,
  input  logic          pkt_ready,
  output logic [CW-1:0] pkt_core,
  output logic [AW-1:0] pkt_axon
);
  localparam logic [CW-1:0] MY_ID = CW'(LOCAL_ID);

  core_state_t   state;
  logic [CNTW-1:0] cnt;
  logic [N-1:0]  act, snap, pending;
  logic [N-1:0]  ev_vec, lb_vec, sel_mask, rrow, fire_hit;
  logic          rvalid, rd_en, has_pend, emit_go, loop_hit;
  logic [AW-1:0] sel_idx, r_axon;
  logic [CW-1:0] r_core;

  assign busy  = (state != ST_IDLE);
  assign rd_en = (state == ST_SCAN) && (cnt < CNTW'(N)) && snap[cnt[AW-1:0]];

  xbar_mem #(.N(N)) u_xbar (
    .clk(clk), .rst(rst), .we(xbar_we), .waddr(xbar_axon), .wrow(xbar_row),
    .re(rd_en), .raddr(cnt[AW-1:0]), .rrow(rrow), .rvalid(rvalid)
  );

  neuron_array #(.N(N), .PW(PW)) u_nrn (
    .clk(clk), .rst(rst), .add_en(rvalid), .add_vec(rrow),
    .fire_en(state == ST_FIRE), .thr(thresh), .fire_hit(fire_hit)
  );

  route_table #(.N(N), .CW(CW)) u_route (
    .clk(clk), .we(route_we), .waddr(route_nrn), .wcore(route_core),
    .waxon(route_axon), .raddr(sel_idx), .rcore(r_core), .raxon(r_axon)
  );

  // lowest pending neuron goes first
  always_comb begin
    sel_idx  = '0;
    has_pend = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pending[i]) begin
        sel_idx  = AW'(i);
        has_pend = 1'b1;
      end
    end
  end

  assign emit_go  = (state == ST_EMIT) && (!pkt_valid || pkt_ready);
  assign loop_hit = emit_go && has_pend && (r_core == MY_ID);

  always_comb begin
    ev_vec   = '0;
    lb_vec   = '0;
    sel_mask = '0;
    if (ev_valid) ev_vec[ev_axon] = 1'b1;
    if (loop_hit) lb_vec[r_axon]  = 1'b1;
    sel_mask[sel_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act  <= '0;
      snap <= '0;
    end else if (state == ST_IDLE && tick) begin
      snap <= act;
      act  <= ev_vec;
    end else begin
      act  <= act | ev_vec | lb_vec;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      pending   <= '0;
      pkt_valid <= 1'b0;
      pkt_core  <= '0;
      pkt_axon  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (tick) begin
          state <= ST_SCAN;
          cnt   <= '0;
        end
        ST_SCAN: begin
          if (cnt == CNTW'(N)) state <= ST_FIRE;
          else                 cnt   <= cnt + 1'b1;
        end
        ST_FIRE: begin
          pending <= fire_hit;
          state   <= ST_EMIT;
        end
        default: if (emit_go) begin
          if (has_pend) begin
            pending   <= pending & ~sel_mask;
            pkt_valid <= (r_core != MY_ID);
            pkt_core  <= r_core;
            pkt_axon  <= r_axon;
          end else begin
            pkt_valid <= 1'b0;
            state     <= ST_IDLE;
          end
        end
      endcase
    end
  end

  // R8: a stalled packet stays put
  assert_pkt_hold_R8: assert property (@(posedge clk) disable iff (rst)
    pkt_valid && !pkt_ready |=> pkt_valid && $stable(pkt_core) && $stable(pkt_axon));

  // R9: no packet is offered once the step is over
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !pkt_valid);

  // R6: spikes for this core never leave through the output
  assert_no_local_out_R6: assert property (@(posedge clk) disable iff (rst)
    pkt_valid |-> pkt_core != MY_ID);

  // R9: a new step only starts from idle
  assert_tick_gate_R9: assert property (@(posedge clk) disable iff (rst)
    busy && !$past(busy) |-> $past(tick));
endmodule

// File: tb/spike_core_test.sv
module spike_core_test;
  localparam int N = 8, PW = 8, CW = 4, AW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [PW-1:0] thresh = 8'd2;
  logic          xbar_we = 1'b0;
  logic [AW-1:0] xbar_axon = '0;
  logic [N-1:0]  xbar_row = '0;
  logic          route_we = 1'b0;
  logic [AW-1:0] route_nrn = '0;
  logic [CW-1:0] route_core = '0;
  logic [AW-1:0] route_axon = '0;
  logic          ev_valid = 1'b0;
  logic [AW-1:0] ev_axon = '0;
  logic          tick = 1'b0;
  logic          busy, pkt_valid;
  logic          pkt_ready = 1'b1;
  logic [CW-1:0] pkt_core;
  logic [AW-1:0] pkt_axon;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  spike_core #(.N(N), .PW(PW), .CW(CW), .LOCAL_ID(3)) uut (
    .clk(clk), .rst(rst), .thresh(thresh), .xbar_we(xbar_we), .xbar_axon(xbar_axon),
    .xbar_row(xbar_row), .route_we(route_we), .route_nrn(route_nrn),
    .route_core(route_core), .route_axon(route_axon), .ev_valid(ev_valid),
    .ev_axon(ev_axon), .tick(tick), .busy(busy), .pkt_valid(pkt_valid),
    .pkt_ready(pkt_ready), .pkt_core(pkt_core), .pkt_axon(pkt_axon)
  );

  // upper byte: axons hit this step; lower byte: neurons expected to fire
  localparam logic [15:0] VEC [8] = '{16'h0100, 16'h0103, 16'h0302, 16'h8001,
                                      16'hFFFF, 16'h0000, 16'h2200, 16'h4444};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_xbar(input int a, input logic [N-1:0] row);
    @(negedge clk);
    xbar_we = 1'b1; xbar_axon = AW'(a); xbar_row = row;
    @(negedge clk);
    xbar_we = 1'b0;
  endtask

  task automatic wr_route(input int n, input int c, input int a);
    @(negedge clk);
    route_we = 1'b1; route_nrn = AW'(n); route_core = CW'(c); route_axon = AW'(a);
    @(negedge clk);
    route_we = 1'b0;
  endtask

  task automatic inject(input int a);
    @(negedge clk);
    ev_valid = 1'b1; ev_axon = AW'(a);
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  // inject a mask, run one step, gather external packets
  task automatic run_tick(input logic [N-1:0] mask, output logic [N-1:0] got,
                          output bit ordered, output bit core_ok);
    int last;
    got = '0; ordered = 1'b1; core_ok = 1'b1; last = -1;
    for (int i = 0; i < N; i++) if (mask[i]) inject(i);
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    for (int k = 0; k < 1000; k++) begin
      if (pkt_valid && pkt_ready) begin
        got[pkt_axon] = 1'b1;
        if (int'(pkt_axon) <= last) ordered = 1'b0;
        last = int'(pkt_axon);
        if (pkt_core != 4'd5) core_ok = 1'b0;
      end
      if (!busy) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [N-1:0] got;
    bit ord, cok;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(!busy && !pkt_valid, "R1 idle after reset", {busy, pkt_valid}, 0);

    // axon i reaches neurons i and i+1; neuron j routes to core 5 axon j
    for (int i = 0; i < N; i++) wr_xbar(i, N'((1 << i) | (1 << ((i + 1) % N))));
    for (int j = 0; j < N; j++) wr_route(j, 5, j);
    thresh = 8'd2;

    // R2 R3 R4 table walk
    for (int t = 0; t < 8; t++) begin
      run_tick(VEC[t][15:8], got, ord, cok);
      chk(got == VEC[t][7:0], $sformatf("R2/R3/R4 step %0d fire set", t), got, VEC[t][7:0]);
      chk(ord && cok, $sformatf("R8 step %0d order and core", t), {ord, cok}, 3);
    end

    // R1: reset clears left-over potentials (neurons 1,3,5,7 hold 1)
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    chk(!busy && !pkt_valid, "R1 outputs after reset", {busy, pkt_valid}, 0);
    thresh = 8'd1;
    run_tick('0, got, ord, cok);
    chk(got == '0, "R1 potentials cleared", got, 0);

    // R10: repeated events on one axon count once; register empties
    thresh = 8'd2;
    inject(0); inject(0);
    run_tick(8'h01, got, ord, cok);
    chk(got == '0, "R10 duplicates count once", got, 0);
    run_tick('0, got, ord, cok);
    chk(got == '0, "R10 register cleared after step", got, 0);
    run_tick(8'h01, got, ord, cok);
    chk(got == 8'h03, "R3 carried potential fires", got, 8'h03);

    // R6 R7: neuron 3 routed to this core (id 3), axon 5
    wr_route(3, 3, 5);
    thresh = 8'd1;
    run_tick(8'h08, got, ord, cok);
    chk(got == 8'h10, "R6 local spike stays off the port", got, 8'h10);
    run_tick('0, got, ord, cok);
    chk(got == 8'h60, "R7 loopback acts next step", got, 8'h60);
    run_tick('0, got, ord, cok);
    chk(got == '0, "R7 loopback consumed once", got, 0);

    // R8 R9: backpressure, tick and event during a busy step
    pkt_ready = 1'b0;
    inject(0);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    for (int k = 0; k < 100 && !pkt_valid; k++) @(negedge clk);
    chk(pkt_valid && pkt_axon == 0, "R8 first packet offered", pkt_axon, 0);
    tick = 1'b1; ev_valid = 1'b1; ev_axon = 3'd6;
    @(negedge clk);
    tick = 1'b0; ev_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(pkt_valid && pkt_axon == 0 && pkt_core == 5, "R8 packet held while stalled",
        pkt_axon, 0);
    pkt_ready = 1'b1;
    @(negedge clk);
    chk(pkt_valid && pkt_axon == 1, "R8 next packet one cycle later", pkt_axon, 1);
    for (int k = 0; k < 100 && busy; k++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(!busy, "R9 tick during busy ignored", busy, 0);
    run_tick('0, got, ord, cok);
    chk(got == 8'hC0, "R9 event during busy kept", got, 8'hC0);

    // R5: every axon reaches every neuron, +8 per step, threshold 255
    for (int i = 0; i < N; i++) wr_xbar(i, 8'hFF);
    thresh = 8'd255;
    begin
      logic [N-1:0] acc;
      acc = '0;
      for (int t = 0; t < 31; t++) begin
        run_tick(8'hFF, got, ord, cok);
        acc |= got;
      end
      chk(acc == '0, "R3 no fire below threshold", acc, 0);
    end
    run_tick(8'hFF, got, ord, cok);
    chk(got == 8'hF7, "R5 saturated potential reaches 255", got, 8'hF7);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule